// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple on-chip request bus and an asynchronous DRAM organised as 1M x 8 with a multiplexed 10-bit address bus. A requester presents a read or write with a 20-bit byte address on a valid/ready handshake. The controller splits the address into a row (upper ten bits) and a column (lower ten bits). It drives the row-strobe, column-strobe, write-enable and output-enable lines, all active low. It also drives the multiplexed address and the data bus with its output enable, and it returns read data with a one-cycle response pulse.

When the next request falls in the row that is already open, the controller leaves the row strobe low and runs another column cycle. A burst to one row therefore costs only column cycles. The page is closed when a request targets another row, when a refresh is pending, or when the row strobe would otherwise stay low past its maximum pulse width. An external refresh request is served between accesses with a column-before-row refresh cycle, and is acknowledged with a one-cycle pulse.

Every strobe spacing is a parameter counted in system clocks and enforced by counters. No edge can come earlier than its minimum.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and after reset with no traffic, the row, column, write and output strobes are all high (inactive), the data bus is not driven and no response is given.
- R2: Request address bits [19:10] go out on the DRAM address bus when the row strobe falls, and bits [9:0] go out when the column strobe falls; the address does not change while the column strobe is low.
- R3: The row strobe stays low for at least T_RAS_MIN clocks each time it falls, and stays high for at least T_RP clocks before it falls again.
- R4: The column strobe falls no sooner than T_RCD clocks after the row strobe falls. It stays low for at least T_CAS clocks and stays high for at least T_CP clocks between pulses.
- R5: A read keeps write-enable high and output-enable low during the column pulse. It samples the DRAM data at the end of that pulse and presents it on rsp_rdata together with a one-cycle rsp_valid.
- R6: A write is an early write. Write-enable is low and the data bus is driven before the column strobe falls. Both are held until the column strobe rises, output-enable is high the whole time, and write-enable does not change while the column strobe is low.
- R7: A request to the row that is already open is served by a new column pulse without the row strobe rising.
- R8: A request to a different row closes the open page, then reopens it with the new row, and the data round-trips correctly.
- R9: A refresh request closes any open page and is served before further accesses. The column strobe falls first and the row strobe falls at least T_CSR clocks later. The data bus is not driven, stored data is unaffected, and ref_ack pulses for one cycle at the end.
- R10: The row strobe is never held low for more than T_RAS_MAX clocks; an idle open page is closed before that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address, row in [19:10], column in [9:0] |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| ref_req | input | 1 | Refresh request, held until ref_ack |
| ref_ack | output | 1 | One-cycle pulse when the refresh cycle ends |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Write data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The hardest case to reach from the ports is the forced close of a page at the maximum row-strobe width. No request ever causes it; it takes a long idle spell with a page left open. The bench builds the controller with a short T_RAS_MAX, opens a page with one write, then holds the bus idle well past the limit. A bus-level DRAM model watches the strobes. It checks that the row strobe rose on its own within the limit and that the data is still readable afterwards. The same model drives read data only after T_CAS column clocks, so early sampling returns a wrong byte.

// File: rtl/fpm_pkg.sv
// Package: shared state encoding for the fast page mode DRAM controller.
package fpm_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,     // page closed, row strobe high
        ST_RCD,      // row strobe low, waiting before column strobe
        ST_CAS,      // column strobe low, access in progress
        ST_CP,       // column strobe high, precharge between pulses
        ST_OPEN,     // page open, deciding hit / close
        ST_CBR_CAS,  // refresh: column strobe low, row strobe still high
        ST_CBR_RAS   // refresh: both strobes low
    } ctrl_state_t;

endpackage

// File: rtl/fpm_phase_timer.sv
// Module: fpm_phase_timer
// Down-counter that times the current controller phase.
// Assumes: load has priority; done is high while the count is zero.
module fpm_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_row_tracker.sv
// Module: fpm_row_tracker
// Remembers which row is open and compares incoming rows against it.
// Assumes: set and clear never occur in the same cycle.
module fpm_row_tracker #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clear,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;
    logic             open_vld;

    // Capture the row on page open, drop validity on page close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row <= '0;
            open_vld <= 1'b0;
        end else if (set) begin
            open_row <= row_in;
            open_vld <= 1'b1;
        end else if (clear) begin
            open_vld <= 1'b0;
        end
    end

    assign hit = open_vld && (open_row == cmp_row);
endmodule

// File: rtl/fpm_ras_window.sv
// Module: fpm_ras_window
// Tracks how long the row strobe has been low (age) and how long it has
// been high (precharge), and flags the minimum/maximum windows.
// Assumes: ras_fall / ras_rise pulse in the cycle the strobe register changes.
module fpm_ras_window #(
    parameter int T_RAS_MIN = 3,
    parameter int T_RAS_MAX = 3000,
    parameter int T_RP      = 2,
    parameter int CLOSE_AGE = 2990
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_fall,
    input  logic ras_rise,
    output logic min_ok,
    output logic near_max,
    output logic rp_done
);
    localparam int AGE_W = $clog2(T_RAS_MAX + 2);
    localparam int RP_W  = $clog2(T_RP + 1);

    logic [AGE_W-1:0] age;
    logic [RP_W-1:0]  rp_left;
    logic             low_q;

    // Count clocks spent with the row strobe low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age   <= '0;
            low_q <= 1'b0;
        end else if (ras_fall) begin
            age   <= AGE_W'(1);
            low_q <= 1'b1;
        end else if (ras_rise) begin
            age   <= '0;
            low_q <= 1'b0;
        end else if (low_q && age != AGE_W'(T_RAS_MAX + 1)) begin
            age <= age + 1'b1;
        end
    end

    // Count down the precharge time after the row strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n)              rp_left <= RP_W'(T_RP - 1);
        else if (ras_rise)       rp_left <= RP_W'(T_RP - 1);
        else if (rp_left != '0)  rp_left <= rp_left - 1'b1;
    end

    assign min_ok   = (age >= AGE_W'(T_RAS_MIN));
    assign near_max = (age >= AGE_W'(CLOSE_AGE));
    assign rp_done  = (rp_left == '0);
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Module: fpm_dram_ctrl
// Host-side controller for a 1M x 8 fast page mode DRAM. It serves reads and
// early writes, keeps a row open for same-row requests, closes it on a miss,
// a refresh or the maximum row-strobe width, and runs column-before-row refresh.
// Assumes: all T_* >= 1; T_RCD + T_CAS covers the row access time;
// T_RAS_MAX is much larger than one page cycle; T_RP >= T_CP.
module fpm_dram_ctrl #(
    parameter int DRAM_AW   = 10,
    parameter int DATA_W    = 8,
    parameter int T_RAS_MIN = 3,
    parameter int T_RAS_MAX = 3000,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_CSR     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [2*DRAM_AW-1:0] req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 ref_req,
    output logic                 ref_ack,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DRAM_AW-1:0]   dram_addr,
    output logic [DATA_W-1:0]    dram_dq_out,
    output logic                 dram_dq_oe,
    input  logic [DATA_W-1:0]    dram_dq_in
);
    import fpm_pkg::*;

    localparam int PAGE_SPAN = 1 + T_CAS + T_CP;
    localparam int CLOSE_AGE = T_RAS_MAX - PAGE_SPAN - 1;
    localparam int MAX_AB    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int MAX_CD    = (T_CP > T_CSR) ? T_CP : T_CSR;
    localparam int MAX_PH    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int PH_W      = $clog2(MAX_PH + 1);
    localparam int CHK_W     = $clog2(T_RAS_MAX + 2);

    ctrl_state_t             state;
    logic [DRAM_AW-1:0]      cur_col;
    logic                    cur_write;

    logic                    tmr_load;
    logic [PH_W-1:0]         tmr_val;
    logic                    tmr_done;
    logic                    row_hit;
    logic                    min_ok, near_max, rp_done;

    logic                    rdy_miss, rdy_hit, accepted;
    logic                    start_cbr, cbr_fire, cbr_end, close_now;
    logic                    ras_fall, ras_rise, row_set;

    wire [DRAM_AW-1:0] req_row = req_addr[2*DRAM_AW-1:DRAM_AW];
    wire [DRAM_AW-1:0] req_col = req_addr[DRAM_AW-1:0];

    fpm_phase_timer #(.W(PH_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    fpm_row_tracker #(.ROW_W(DRAM_AW)) i_rows (
        .clk(clk), .rst_n(rst_n), .set(row_set), .clear(ras_rise),
        .row_in(req_row), .cmp_row(req_row), .hit(row_hit)
    );

    fpm_ras_window #(
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP),
        .CLOSE_AGE(CLOSE_AGE)
    ) i_window (
        .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .min_ok(min_ok), .near_max(near_max), .rp_done(rp_done)
    );

    // Decide acceptance, page close, refresh start and phase timer loads.
    always_comb begin
        rdy_miss  = (state == ST_IDLE) && rp_done && !ref_req;
        rdy_hit   = (state == ST_OPEN) && row_hit && !ref_req && !near_max;
        req_ready = rdy_miss || rdy_hit;
        accepted  = req_valid && req_ready;
        start_cbr = (state == ST_IDLE) && rp_done && ref_req;
        cbr_fire  = (state == ST_CBR_CAS) && tmr_done;
        cbr_end   = (state == ST_CBR_RAS) && min_ok;
        close_now = (state == ST_OPEN) && min_ok &&
                    (ref_req || near_max || (req_valid && !row_hit));
        row_set   = accepted && (state == ST_IDLE);
        ras_fall  = row_set || cbr_fire;
        ras_rise  = close_now || cbr_end;

        tmr_load = 1'b0;
        tmr_val  = '0;
        if (row_set) begin
            tmr_load = 1'b1;
            tmr_val  = PH_W'(T_RCD - 1);
        end else if (accepted) begin
            tmr_load = 1'b1;
            tmr_val  = '0;
        end else if (state == ST_RCD && tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = PH_W'(T_CAS - 1);
        end else if (state == ST_CAS && tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = PH_W'(T_CP - 1);
        end else if (start_cbr) begin
            tmr_load = 1'b1;
            tmr_val  = PH_W'(T_CSR - 1);
        end
    end

    // Sequence the strobes, address mux, data drive and responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            cur_col     <= '0;
            cur_write   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            ref_ack     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            ref_ack   <= 1'b0;
            if (accepted) begin
                cur_col     <= req_col;
                cur_write   <= req_write;
                dram_we_n   <= !req_write;
                dram_dq_out <= req_wdata;
                dram_dq_oe  <= req_write;
            end
            case (state)
                ST_IDLE: begin
                    if (row_set) begin
                        dram_ras_n <= 1'b0;
                        dram_addr  <= req_row;
                        state      <= ST_RCD;
                    end else if (start_cbr) begin
                        dram_cas_n <= 1'b0;
                        state      <= ST_CBR_CAS;
                    end
                end
                ST_RCD: begin
                    if (tmr_done) begin
                        dram_cas_n <= 1'b0;
                        dram_addr  <= cur_col;
                        dram_oe_n  <= cur_write;
                        state      <= ST_CAS;
                    end
                end
                ST_CAS: begin
                    if (tmr_done) begin
                        if (!cur_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= dram_dq_in;
                        end
                        dram_cas_n <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dram_we_n  <= 1'b1;
                        dram_dq_oe <= 1'b0;
                        state      <= ST_CP;
                    end
                end
                ST_CP: begin
                    if (tmr_done) state <= ST_OPEN;
                end
                ST_OPEN: begin
                    if (accepted) begin
                        state <= ST_RCD;
                    end else if (close_now) begin
                        dram_ras_n <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_CBR_CAS: begin
                    if (cbr_fire) begin
                        dram_ras_n <= 1'b0;
                        state      <= ST_CBR_RAS;
                    end
                end
                ST_CBR_RAS: begin
                    if (cbr_end) begin
                        dram_ras_n <= 1'b1;
                        dram_cas_n <= 1'b1;
                        ref_ack    <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Independent strobe-width counters observed from the output pins.
    logic [CHK_W-1:0] chk_low, chk_high;

    // Count clocks the row strobe pin is seen low / high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_low  <= '0;
            chk_high <= '0;
        end else begin
            chk_low  <= dram_ras_n ? '0 :
                        (chk_low == CHK_W'(T_RAS_MAX + 1) ? chk_low : chk_low + 1'b1);
            chk_high <= !dram_ras_n ? '0 :
                        (chk_high == CHK_W'(T_RP) ? chk_high : chk_high + 1'b1);
        end
    end

    AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> chk_low >= CHK_W'(T_RAS_MIN)); // R3
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> chk_high >= CHK_W'(T_RP)); // R3
    AST_RAS_MAX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        chk_low <= CHK_W'(T_RAS_MAX)); // R10
    AST_ADDR_HELD_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr)); // R2
    AST_WE_HELD_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_ras_n && $past(!dram_cas_n)) |-> $stable(dram_we_n)); // R6
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_dq_oe && !dram_oe_n)); // R6
    AST_REFRESH_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> !dram_dq_oe); // R9
    AST_CAS_FALLS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n)); // R4
endmodule

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
    localparam int T_RAS_MIN = 3;
    localparam int T_RAS_MAX = 60;
    localparam int T_RP      = 2;
    localparam int T_RCD     = 2;
    localparam int T_CAS     = 2;
    localparam int T_CP      = 1;
    localparam int T_CSR     = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, ref_ack;
    logic [7:0] rsp_rdata;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0] dram_addr;
    logic [7:0] dram_dq_out;
    logic [7:0] dram_dq_in = 8'hEE;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpm_dram_ctrl #(
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_CSR(T_CSR)
    ) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
        .ref_ack(ref_ack), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // ---------------- DRAM bus model with timing monitor ----------------
    logic [7:0] mem [int];
    logic [9:0] m_row, m_col;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100;
    int ras_falls = 0, cbr_cnt = 0;
    int v_r3 = 0, v_r4 = 0, v_r6 = 0, v_r9 = 0, v_r10 = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n) begin
                if (p_ras) begin
                    if (ras_hi < T_RP) v_r3++;
                    ras_falls++;
                    if (!dram_cas_n) begin
                        cbr_cnt++;
                        if (dram_dq_oe) v_r9++;
                    end else m_row = dram_addr;
                    ras_lo = 1;
                end else ras_lo++;
                if (ras_lo > T_RAS_MAX) v_r10++;
            end else begin
                if (!p_ras) begin
                    if (ras_lo < T_RAS_MIN) v_r3++;
                    ras_hi = 1;
                end else ras_hi++;
            end
            if (!dram_cas_n) begin
                if (p_cas) begin
                    if (!dram_ras_n) begin
                        if (ras_lo <= T_RCD) v_r4++;
                        if (cas_hi < T_CP) v_r4++;
                        m_col = dram_addr;
                        if (!dram_we_n) begin
                            if (!dram_dq_oe) v_r6++;
                            mem[int'({m_row, m_col})] = dram_dq_out;
                        end
                    end
                    cas_lo = 1;
                end else begin
                    cas_lo++;
                    if (!dram_ras_n && dram_we_n != p_we) v_r6++;
                    if (!dram_ras_n && !dram_we_n && !dram_dq_oe) v_r6++;
                end
            end else begin
                if (!p_cas) begin
                    if (cas_lo < T_CAS) v_r4++;
                    cas_hi = 1;
                end else cas_hi++;
            end
            if (dram_dq_oe && !dram_oe_n) v_r6++;
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n && cas_lo >= T_CAS)
                dram_dq_in = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 8'h00;
            else
                dram_dq_in = 8'hEE;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a, output logic [7:0] d);
        issue(1'b0, a, 8'h00);
        d = 8'hXX;
        for (int k = 0; k < 100; k++) begin
            if (rsp_valid) begin
                d = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_refresh();
        @(negedge clk);
        ref_req = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (ref_ack) break;
        end
        ref_req = 1'b0;
    endtask

    task automatic finish_run();
        check(v_r3 == 0,  "R3 row strobe width/precharge violations", v_r3, 0);
        check(v_r4 == 0,  "R4 column strobe spacing violations", v_r4, 0);
        check(v_r6 == 0,  "R6 write strobe/data violations", v_r6, 0);
        check(v_r9 == 0,  "R9 bus driven during refresh", v_r9, 0);
        check(v_r10 == 0, "R10 row strobe over maximum", v_r10, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Stimulus table: {op[1:0], addr[19:0], data[7:0]}; op 0 read, 1 write, 2 refresh.
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {2'd1, 20'h00403, 8'hA5},
        {2'd1, 20'h00404, 8'h3C},
        {2'd0, 20'h00403, 8'hA5},
        {2'd0, 20'h00404, 8'h3C},
        {2'd1, 20'hFFC01, 8'h77},
        {2'd0, 20'h00403, 8'hA5},
        {2'd2, 20'h00000, 8'h00},
        {2'd0, 20'hFFC01, 8'h77},
        {2'd1, 20'h00000, 8'h01},
        {2'd0, 20'h00000, 8'h01}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int f0, c0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
              "R1 idle strobes in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(dram_ras_n && dram_cas_n && !dram_dq_oe, "R1 idle strobes after reset",
              {dram_ras_n, dram_cas_n, dram_dq_oe}, 3'b110);

        // Table walk: R5 reads, R6 writes, R8 row changes, R9 refresh in stream
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][29:28])
                2'd1: issue(1'b1, VEC[i][27:8], VEC[i][7:0]);
                2'd2: do_refresh();
                default: begin
                    do_read(VEC[i][27:8], rd);
                    check(rd == VEC[i][7:0], $sformatf("R5 read data vector %0d", i),
                          rd, VEC[i][7:0]);
                end
            endcase
        end

        // R2: row/column split lands at the expected cell
        check(mem.exists(int'(20'h00404)) && mem[int'(20'h00404)] == 8'h3C,
              "R2 cell row 1 col 4", mem.exists(int'(20'h00404)) ? mem[int'(20'h00404)] : 0, 8'h3C);
        check(mem.exists(int'(20'hFFC01)) && mem[int'(20'hFFC01)] == 8'h77,
              "R2 cell row 1023 col 1", mem.exists(int'(20'hFFC01)) ? mem[int'(20'hFFC01)] : 0, 8'h77);

        // R7: page hits keep the row strobe low
        repeat (80) @(negedge clk);
        f0 = ras_falls;
        issue(1'b1, 20'h01410, 8'h5A);
        issue(1'b1, 20'h01411, 8'h6B);
        do_read(20'h01410, rd);
        check(rd == 8'h5A, "R7 page hit read data", rd, 8'h5A);
        check(ras_falls - f0 == 1, "R7 one row open for three same-row accesses",
              ras_falls - f0, 1);

        // R8: miss closes page and reopens with new row
        f0 = ras_falls;
        do_read(20'h00403, rd);
        check(rd == 8'hA5, "R8 miss read data", rd, 8'hA5);
        check(ras_falls - f0 == 1, "R8 row reopened on miss", ras_falls - f0, 1);

        // R9: refresh closes open page, data kept, no access
        f0 = ras_falls; c0 = cbr_cnt;
        do_refresh();
        check(cbr_cnt - c0 == 1, "R9 refresh cycle seen", cbr_cnt - c0, 1);
        do_read(20'h01411, rd);
        check(rd == 8'h6B, "R9 data intact after refresh", rd, 8'h6B);
        check(ras_falls - f0 == 2, "R9 page reopened after refresh", ras_falls - f0, 2);

        // R10: idle open page is closed before the maximum width
        issue(1'b1, 20'h02020, 8'hC3);
        repeat (T_RAS_MAX + 20) @(negedge clk);
        check(dram_ras_n == 1'b1, "R10 idle page closed", dram_ras_n, 1);
        do_read(20'h02020, rd);
        check(rd == 8'hC3, "R10 data after forced close", rd, 8'hC3);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule